// File: doc/BRIEF.md
# DMA Completion Action Unit

This unit runs the follow-up work of a DMA instruction after its data has been moved. Once per finished transfer, the engine presents the instruction's latched header bits on a valid/ready input: the transfer kind, the counter-select bit, the count-enable bit, the force-interrupt bit, the notify-kind bit and a 40-bit notify pointer. It also presents the total byte count of the transfer. From these the unit works out which side effects apply and performs them.

The side effects are as follows. It can add to one of two saturating completion counters, either by one or by the byte count, as a global mode bit selects. It can raise one of two sticky forced-interrupt flags. It can issue a work-queue submission request that carries the pointer. It can issue a request to clear a single byte in local memory, with the byte lane chosen by a global endianness bit. Each outgoing request has its own valid/ready handshake. A new completion is taken only after every request raised by the previous one has been handed off.

If a header field combination is not allowed, the unit sets a sticky error flag and skips the action that the bad field would have caused.

Top module: `dma_done_actions`

## Requirements
- R1: An accepted completion of kind outbound (code 0) or external (code 3) with the count-enable bit set updates counter 0 when the select bit is 0 and counter 1 when it is 1, one cycle after acceptance. With count-enable clear, neither counter changes.
- R2: A counter update adds 1 when `add_one` is high and adds `cmp_bytes` when it is low.
- R3: A counter never wraps: a sum past all-ones leaves the counter at all-ones.
- R4: A high `clr_cnt[i]` zeroes counter i on the next cycle. This takes precedence over an update to the same counter in the same cycle.
- R5: An accepted outbound or external completion with the force-interrupt bit set raises `irq_flag[sel]`. The flag stays set until `clr_irq[sel]` is pulsed, and a set in the same cycle as the clear wins.
- R6: Kind codes are 0 outbound, 1 inbound, 2 internal and 3 external. For inbound and internal completions, no counter or interrupt flag ever changes. If any of the select, count-enable or force-interrupt bits is set on such a completion, `err_flag` is raised.
- R7: With the notify-kind bit at 1 and a nonzero pointer whose bits [2:0] are zero, a work-queue request carrying the pointer is raised. If bits [2:0] are nonzero, `err_flag` is raised and no request is made.
- R8: With the notify-kind bit at 0 and a nonzero pointer, a byte-clear request is raised. Its `bw_addr` is the pointer with bits [2:0] forced to zero. `bw_lane` is one-hot: bit ptr[2:0] is set when `byte_le` is 1, and bit 7-ptr[2:0] is set when `byte_le` is 0.
- R9: A zero pointer raises no work-queue request and no byte-clear request.
- R10: A raised request stays valid with unchanged payload until its ready is seen. `cmp_ready` is low while any request is pending.
- R11: `err_flag` stays set until `clr_err` is pulsed, and a new error in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Completion presented |
| cmp_ready | output | 1 | Completion can be accepted |
| cmp_kind | input | 2 | Transfer kind code |
| cmp_wq | input | 1 | Notify kind: 1 work-queue entry, 0 byte flag |
| cmp_sel | input | 1 | Counter / interrupt select |
| cmp_add | input | 1 | Count-enable bit |
| cmp_irq | input | 1 | Force-interrupt bit |
| cmp_ptr | input | PTR_W | Notify pointer |
| cmp_bytes | input | BYTES_W | Total bytes of the transfer |
| add_one | input | 1 | Global mode: counters add one |
| byte_le | input | 1 | Global byte-lane endianness |
| clr_cnt | input | 2 | Per-counter clear strobe |
| clr_irq | input | 2 | Per-flag interrupt clear strobe |
| clr_err | input | 1 | Error flag clear strobe |
| cnt0 | output | CNT_W | Completion counter 0 |
| cnt1 | output | CNT_W | Completion counter 1 |
| irq_flag | output | 2 | Forced-interrupt flags |
| err_flag | output | 1 | Sticky illegal-field flag |
| wq_valid | output | 1 | Work-queue request valid |
| wq_ready | input | 1 | Work-queue request taken |
| wq_ptr | output | PTR_W | Work-queue entry pointer |
| bw_valid | output | 1 | Byte-clear request valid |
| bw_ready | input | 1 | Byte-clear request taken |
| bw_addr | output | PTR_W | Aligned word address of the byte |
| bw_lane | output | 8 | One-hot byte lane to clear |

## Verification
The assertions watch several rules on every cycle. A counter never wraps. A clear always lands. A counter is left alone when nothing addresses it. Inbound and internal completions never touch the counters. Interrupt and error flags hold until cleared. A pending request keeps its payload, is never overwritten, and never coexists with the other kind. A zero pointer never starts a request. Other behaviour only the bench's scenarios can show: the exact values added in each mode, saturation at the top, the precedence rules when a clear and an event collide, the lane choice in each endianness, and that a misaligned work-queue pointer is rejected.

// File: rtl/dma_done_pkg.sv
`timescale 1ns/1ps
package dma_done_pkg;

  typedef enum logic [1:0] {
    XFER_OUT = 2'd0,
    XFER_IN  = 2'd1,
    XFER_LOC = 2'd2,
    XFER_EXT = 2'd3
  } xfer_kind_e;

  typedef struct packed {
    logic [1:0] cnt_hit;
    logic [1:0] irq_hit;
    logic       wq_go;
    logic       bw_go;
    logic       bad;
  } done_plan_t;

endpackage

// File: rtl/dma_done_rst_sync.sv
`timescale 1ns/1ps
module dma_done_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/dma_done_decode.sv
`timescale 1ns/1ps
module dma_done_decode
  import dma_done_pkg::*;
#(
  parameter int PTR_W = 40
) (
  input  logic [1:0]       kind,
  input  logic             wq_sel,
  input  logic             cnt_sel,
  input  logic             cnt_add,
  input  logic             irq_force,
  input  logic [PTR_W-1:0] ptr,
  output done_plan_t       plan
);

  xfer_kind_e k;
  logic remote, ptr_zero, misalign, flag_bad;

  always_comb begin
    k        = xfer_kind_e'(kind);
    remote   = (k == XFER_OUT) || (k == XFER_EXT);
    ptr_zero = (ptr == '0);
    misalign = wq_sel && !ptr_zero && (ptr[2:0] != 3'b000);
    flag_bad = !remote && (cnt_sel || cnt_add || irq_force);

    plan.cnt_hit[0] = remote && cnt_add   && !cnt_sel;
    plan.cnt_hit[1] = remote && cnt_add   &&  cnt_sel;
    plan.irq_hit[0] = remote && irq_force && !cnt_sel;
    plan.irq_hit[1] = remote && irq_force &&  cnt_sel;
    plan.wq_go      = wq_sel && !ptr_zero && !misalign;
    plan.bw_go      = !wq_sel && !ptr_zero;
    plan.bad        = flag_bad || misalign;
  end

endmodule

// File: rtl/dma_done_counter.sv
`timescale 1ns/1ps
module dma_done_counter #(
  parameter int CNT_W   = 32,
  parameter int BYTES_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               bump,
  input  logic               add_one,
  input  logic [BYTES_W-1:0] bytes,
  output logic [CNT_W-1:0]   cnt
);

  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, inc;
  logic [SUM_W-1:0] sum;
  logic             cnt_en;

  always_comb begin
    inc    = add_one ? CNT_W'(1) : CNT_W'(bytes);
    sum    = {1'b0, cnt_q} + {1'b0, inc};
    cnt_en = clr || bump;
    cnt_d  = cnt_q;
    if (clr)       cnt_d = '0;
    else if (bump) cnt_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !clr) |=> (cnt_q >= $past(cnt_q)))
    else $error("counter wrapped");

  assert_clear_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0))
    else $error("clear did not zero counter");

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump && !clr) |=> $stable(cnt_q))
    else $error("counter moved without update");

endmodule

// File: rtl/dma_done_slot.sv
`timescale 1ns/1ps
module dma_done_slot #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         v_q, v_d;
  logic [W-1:0] d_q;

  always_comb begin
    v_d = v_q;
    if (load)                  v_d = 1'b1;
    else if (v_q && out_ready) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    d_q <= '0;
    else if (load) d_q <= load_data;
  end

  assign out_valid = v_q;
  assign out_data  = d_q;

  assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !v_q)
    else $error("request overwritten while pending");

  assert_hold_payload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !out_ready) |=> (v_q && $stable(d_q)))
    else $error("pending request dropped or changed");

endmodule

// File: rtl/dma_done_actions.sv
`timescale 1ns/1ps
module dma_done_actions
  import dma_done_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int BYTES_W = 16,
  parameter int PTR_W   = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_valid,
  output logic               cmp_ready,
  input  logic [1:0]         cmp_kind,
  input  logic               cmp_wq,
  input  logic               cmp_sel,
  input  logic               cmp_add,
  input  logic               cmp_irq,
  input  logic [PTR_W-1:0]   cmp_ptr,
  input  logic [BYTES_W-1:0] cmp_bytes,
  input  logic               add_one,
  input  logic               byte_le,
  input  logic [1:0]         clr_cnt,
  input  logic [1:0]         clr_irq,
  input  logic               clr_err,
  output logic [CNT_W-1:0]   cnt0,
  output logic [CNT_W-1:0]   cnt1,
  output logic [1:0]         irq_flag,
  output logic               err_flag,
  output logic               wq_valid,
  input  logic               wq_ready,
  output logic [PTR_W-1:0]   wq_ptr,
  output logic               bw_valid,
  input  logic               bw_ready,
  output logic [PTR_W-1:0]   bw_addr,
  output logic [7:0]         bw_lane
);

  localparam int NUM_CNT = 2;
  localparam int BW_W    = PTR_W + 8;

  logic             rst_s_n;
  logic             accept;
  done_plan_t       plan;
  logic [CNT_W-1:0] cnt_q [NUM_CNT];
  logic [1:0]       irq_q, irq_d;
  logic             err_q, err_d;
  logic [2:0]       lane_idx;
  logic [7:0]       lane;
  logic [BW_W-1:0]  bw_load, bw_out;

  dma_done_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  dma_done_decode #(.PTR_W(PTR_W)) u_dec (
    .kind      (cmp_kind),
    .wq_sel    (cmp_wq),
    .cnt_sel   (cmp_sel),
    .cnt_add   (cmp_add),
    .irq_force (cmp_irq),
    .ptr       (cmp_ptr),
    .plan      (plan)
  );

  assign cmp_ready = !(wq_valid || bw_valid);
  assign accept    = cmp_valid && cmp_ready;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    dma_done_counter #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .clr     (clr_cnt[g]),
      .bump    (accept && plan.cnt_hit[g]),
      .add_one (add_one),
      .bytes   (cmp_bytes),
      .cnt     (cnt_q[g])
    );
  end

  assign cnt0 = cnt_q[0];
  assign cnt1 = cnt_q[1];

  always_comb begin
    irq_d = irq_q;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (accept && plan.irq_hit[i]) irq_d[i] = 1'b1;
      else if (clr_irq[i])           irq_d[i] = 1'b0;
    end
    err_d = err_q;
    if (accept && plan.bad) err_d = 1'b1;
    else if (clr_err)       err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      irq_q <= '0;
      err_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      err_q <= err_d;
    end
  end

  assign irq_flag = irq_q;
  assign err_flag = err_q;

  always_comb begin
    lane_idx = byte_le ? cmp_ptr[2:0] : ~cmp_ptr[2:0];
    lane     = 8'b1 << lane_idx;
    bw_load  = {cmp_ptr[PTR_W-1:3], 3'b000, lane};
  end

  dma_done_slot #(.W(PTR_W)) u_wq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .load      (accept && plan.wq_go),
    .load_data (cmp_ptr),
    .out_valid (wq_valid),
    .out_ready (wq_ready),
    .out_data  (wq_ptr)
  );

  dma_done_slot #(.W(BW_W)) u_bw (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .load      (accept && plan.bw_go),
    .load_data (bw_load),
    .out_valid (bw_valid),
    .out_ready (bw_ready),
    .out_data  (bw_out)
  );

  assign bw_addr = bw_out[BW_W-1:8];
  assign bw_lane = bw_out[7:0];

  assert_local_quiet_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmp_valid && cmp_ready && (cmp_kind == 2'd1 || cmp_kind == 2'd2) && clr_cnt == 2'b00)
    |=> ($stable(cnt0) && $stable(cnt1)))
    else $error("inbound/internal completion moved a counter");

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq_flag[0] && !clr_irq[0]) |=> irq_flag[0])
    else $error("interrupt flag 0 dropped");

  assert_irq1_sticky_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq_flag[1] && !clr_irq[1]) |=> irq_flag[1])
    else $error("interrupt flag 1 dropped");

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (err_flag && !clr_err) |=> err_flag)
    else $error("error flag dropped");

  assert_zero_ptr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmp_valid && cmp_ready && cmp_ptr == '0) |=> (!wq_valid && !bw_valid))
    else $error("zero pointer raised a request");

  assert_single_request_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(wq_valid && bw_valid))
    else $error("two requests pending at once");

endmodule

// File: tb/dma_done_actions_test.sv
`timescale 1ns/1ps
module dma_done_actions_test;

  localparam int CW = 20;
  localparam int BWD = 16;
  localparam int PW = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmp_valid, cmp_ready;
  logic [1:0]    cmp_kind;
  logic          cmp_wq, cmp_sel, cmp_add, cmp_irq;
  logic [PW-1:0] cmp_ptr;
  logic [BWD-1:0] cmp_bytes;
  logic          add_one, byte_le;
  logic [1:0]    clr_cnt, clr_irq;
  logic          clr_err;
  logic [CW-1:0] cnt0, cnt1;
  logic [1:0]    irq_flag;
  logic          err_flag;
  logic          wq_valid, wq_ready, bw_valid, bw_ready;
  logic [PW-1:0] wq_ptr, bw_addr;
  logic [7:0]    bw_lane;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [CW-1:0] m_cnt [2];
  logic [1:0]    m_irq;
  logic          m_err;

  always #2.5 clk = ~clk;

  dma_done_actions #(.CNT_W(CW), .BYTES_W(BWD), .PTR_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
    .cmp_kind(cmp_kind), .cmp_wq(cmp_wq), .cmp_sel(cmp_sel), .cmp_add(cmp_add),
    .cmp_irq(cmp_irq), .cmp_ptr(cmp_ptr), .cmp_bytes(cmp_bytes),
    .add_one(add_one), .byte_le(byte_le), .clr_cnt(clr_cnt), .clr_irq(clr_irq),
    .clr_err(clr_err), .cnt0(cnt0), .cnt1(cnt1), .irq_flag(irq_flag),
    .err_flag(err_flag), .wq_valid(wq_valid), .wq_ready(wq_ready), .wq_ptr(wq_ptr),
    .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_addr(bw_addr), .bw_lane(bw_lane)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (ok !== 1'b1) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] c, input logic [BWD-1:0] inc);
    logic [CW:0] s;
    s = {1'b0, c} + (CW+1)'(inc);
    return s[CW] ? '1 : s[CW-1:0];
  endfunction

  function automatic logic [7:0] exp_lane(input logic le, input logic [2:0] p);
    return le ? (8'b1 << p) : (8'b1 << (3'd7 - p));
  endfunction

  task automatic check_state();
    chk(cnt0 === m_cnt[0], "R1 R2 R3 R4 counter 0", 64'(cnt0), 64'(m_cnt[0]));
    chk(cnt1 === m_cnt[1], "R1 R2 R3 R4 counter 1", 64'(cnt1), 64'(m_cnt[1]));
    chk(irq_flag === m_irq, "R5 R6 interrupt flags", 64'(irq_flag), 64'(m_irq));
    chk(err_flag === m_err, "R11 R6 R7 error flag", 64'(err_flag), 64'(m_err));
  endtask

  task automatic strobe(input logic [1:0] cc, input logic [1:0] ci, input logic ce);
    @(negedge clk);
    clr_cnt = cc; clr_irq = ci; clr_err = ce;
    for (int i = 0; i < 2; i++) begin
      if (cc[i]) m_cnt[i] = '0;
      if (ci[i]) m_irq[i] = 1'b0;
    end
    if (ce) m_err = 1'b0;
    @(negedge clk);
    clr_cnt = '0; clr_irq = '0; clr_err = 1'b0;
    check_state();
  endtask

  task automatic send(input logic [1:0] k, input logic w, input logic s, input logic a,
                      input logic f, input logic [PW-1:0] p, input logic [BWD-1:0] b,
                      input logic [1:0] cc, input logic [1:0] ci, input logic ce,
                      input int stall);
    logic remote, fbad, mis, ewq, ebw;
    @(negedge clk);
    chk(cmp_ready === 1'b1, "R10 idle ready", 64'(cmp_ready), 64'd1);
    cmp_kind = k; cmp_wq = w; cmp_sel = s; cmp_add = a; cmp_irq = f;
    cmp_ptr = p; cmp_bytes = b; cmp_valid = 1'b1;
    clr_cnt = cc; clr_irq = ci; clr_err = ce;
    remote = (k == 2'd0) || (k == 2'd3);
    fbad   = !remote && (s || a || f);
    mis    = w && (p != '0) && (p[2:0] != 3'b000);
    ewq    = w && (p != '0) && !mis;
    ebw    = !w && (p != '0);
    for (int i = 0; i < 2; i++) begin
      if (cc[i]) m_cnt[i] = '0;
      else if (remote && a && (int'(s) == i)) m_cnt[i] = sat_add(m_cnt[i], add_one ? BWD'(1) : b);
      if (remote && f && (int'(s) == i)) m_irq[i] = 1'b1;
      else if (ci[i]) m_irq[i] = 1'b0;
    end
    if (fbad || mis) m_err = 1'b1;
    else if (ce)     m_err = 1'b0;
    @(negedge clk);
    cmp_valid = 1'b0; clr_cnt = '0; clr_irq = '0; clr_err = 1'b0;
    check_state();
    chk(wq_valid === ewq, "R7 R9 work-queue valid", 64'(wq_valid), 64'(ewq));
    chk(bw_valid === ebw, "R8 R9 byte-clear valid", 64'(bw_valid), 64'(ebw));
    if (ewq) chk(wq_ptr === p, "R7 work-queue pointer", 64'(wq_ptr), 64'(p));
    if (ebw) begin
      chk(bw_addr === {p[PW-1:3], 3'b000}, "R8 byte-clear address", 64'(bw_addr), 64'({p[PW-1:3], 3'b000}));
      chk(bw_lane === exp_lane(byte_le, p[2:0]), "R8 byte lane", 64'(bw_lane), 64'(exp_lane(byte_le, p[2:0])));
    end
    if (ewq || ebw) begin
      chk(cmp_ready === 1'b0, "R10 busy while pending", 64'(cmp_ready), 64'd0);
      for (int t = 0; t < stall; t++) begin
        @(negedge clk);
        chk((wq_valid === ewq) && (bw_valid === ebw), "R10 held valid", 64'({wq_valid, bw_valid}), 64'({ewq, ebw}));
        if (ewq) chk(wq_ptr === p, "R10 held pointer", 64'(wq_ptr), 64'(p));
        if (ebw) chk(bw_addr === {p[PW-1:3], 3'b000}, "R10 held address", 64'(bw_addr), 64'({p[PW-1:3], 3'b000}));
      end
      wq_ready = 1'b1; bw_ready = 1'b1;
      @(negedge clk);
      wq_ready = 1'b0; bw_ready = 1'b0;
      chk(!wq_valid && !bw_valid, "R10 request handed off", 64'({wq_valid, bw_valid}), 64'd0);
      chk(cmp_ready === 1'b1, "R10 ready after hand-off", 64'(cmp_ready), 64'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D0C_5EED));
    rst_n = 1'b0; cmp_valid = 1'b0; cmp_kind = '0; cmp_wq = 1'b0; cmp_sel = 1'b0;
    cmp_add = 1'b0; cmp_irq = 1'b0; cmp_ptr = '0; cmp_bytes = '0;
    add_one = 1'b0; byte_le = 1'b0; clr_cnt = '0; clr_irq = '0; clr_err = 1'b0;
    wq_ready = 1'b0; bw_ready = 1'b0;
    m_cnt[0] = '0; m_cnt[1] = '0; m_irq = '0; m_err = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state
    check_state();
    chk(!wq_valid && !bw_valid && cmp_ready, "reset outputs", 64'({wq_valid, bw_valid, cmp_ready}), 64'd1);

    // R1 R2: byte-count mode, each counter
    send(2'd0, 0, 0, 1, 0, '0, 16'd100, 2'b00, 2'b00, 0, 0);
    send(2'd3, 0, 1, 1, 0, '0, 16'd7,   2'b00, 2'b00, 0, 0);
    // R2: add-one mode
    add_one = 1'b1;
    send(2'd0, 0, 0, 1, 0, '0, 16'd500, 2'b00, 2'b00, 0, 0);
    add_one = 1'b0;
    // R1: count-enable clear leaves counters
    send(2'd0, 0, 0, 0, 0, '0, 16'd55, 2'b00, 2'b00, 0, 0);
    // R5: forced interrupt on flag 1
    send(2'd3, 0, 1, 0, 1, '0, 16'd1, 2'b00, 2'b00, 0, 0);
    // R6: inbound with count-enable is an error and moves nothing
    send(2'd1, 0, 0, 1, 1, '0, 16'd9, 2'b00, 2'b00, 0, 0);
    send(2'd2, 0, 1, 0, 0, '0, 16'd9, 2'b00, 2'b00, 0, 0);
    // R11: clear the error
    strobe(2'b00, 2'b00, 1'b1);
    // R7: aligned and misaligned work-queue pointers
    send(2'd1, 1, 0, 0, 0, 40'h12_3456_7890, 16'd4, 2'b00, 2'b00, 0, 2);
    send(2'd1, 1, 0, 0, 0, 40'h12_3456_7893, 16'd4, 2'b00, 2'b00, 0, 0);
    strobe(2'b00, 2'b00, 1'b1);
    // R8: byte lane in both endianness settings
    byte_le = 1'b1;
    send(2'd2, 0, 0, 0, 0, 40'hAB_CDEF_0125, 16'd4, 2'b00, 2'b00, 0, 1);
    byte_le = 1'b0;
    send(2'd2, 0, 0, 0, 0, 40'hAB_CDEF_0125, 16'd4, 2'b00, 2'b00, 0, 3);
    // R9: zero pointer raises nothing
    send(2'd0, 1, 0, 0, 0, '0, 16'd4, 2'b00, 2'b00, 0, 0);
    send(2'd0, 0, 0, 0, 0, '0, 16'd4, 2'b00, 2'b00, 0, 0);
    // R3: saturate counter 0
    strobe(2'b01, 2'b00, 1'b0);
    for (int i = 0; i < 18; i++) send(2'd0, 0, 0, 1, 0, '0, 16'hFFFF, 2'b00, 2'b00, 0, 0);
    chk(cnt0 === {CW{1'b1}}, "R3 saturated value", 64'(cnt0), 64'({CW{1'b1}}));
    // R4: clear beats a same-cycle update
    send(2'd0, 0, 0, 1, 0, '0, 16'd3, 2'b01, 2'b00, 0, 0);
    // R5: set beats a same-cycle clear
    send(2'd0, 0, 0, 0, 1, '0, 16'd3, 2'b00, 2'b01, 0, 0);
    strobe(2'b00, 2'b11, 1'b0);
    // R11: new error beats a same-cycle clear
    send(2'd1, 0, 1, 0, 0, '0, 16'd3, 2'b00, 2'b00, 1, 0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] k; logic s, a, f, w; logic [PW-1:0] p; int ps;
      k = 2'($urandom % 4);
      if ((k == 2'd0) || (k == 2'd3) || ($urandom % 8 == 0)) begin
        s = 1'($urandom); a = 1'($urandom); f = 1'($urandom);
      end else begin
        s = 1'b0; a = 1'b0; f = 1'b0;
      end
      w = 1'($urandom);
      ps = int'($urandom % 4);
      p = PW'({$urandom, $urandom});
      if (ps == 0) p = '0;
      else if (ps == 1) p[2:0] = 3'b000;
      add_one = ($urandom % 4 == 0);
      byte_le = 1'($urandom);
      send(k, w, s, a, f, p, 16'($urandom),
           ($urandom % 16 == 0) ? 2'($urandom) : 2'b00,
           ($urandom % 16 == 0) ? 2'($urandom) : 2'b00,
           ($urandom % 16 == 0), int'($urandom % 3));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule